// File: doc/BRIEF.md
# Multi-mode receive DMA channel

This block sits between a serial receive engine and system memory. Incoming bytes and frame-end markers enter a small FIFO. A write engine then stores each data byte into a circular buffer, which lies between a programmed lower and upper address. A processor programs the buffer window, the write pointer, the interrupt conditions and the operating mode through a simple register port. It can read the write pointer back at any time to work out how many bytes have arrived.

The mode sets when the channel asks for attention. In frame mode, two bytes are set aside in front of every frame. When the frame ends, the engine fills them with the frame's byte count and a status byte, and the next frame starts directly after the last data byte. In the other three modes, no count is stored in memory and frame-end markers are discarded. Periodic mode interrupts after every n stored bytes, using a down-counter that reloads itself. Silence mode interrupts when a programmed number of cycles passes without a new character. Match mode interrupts once a stored byte equals any of four enabled match characters.

Top module: `rxdma_chan`

## Requirements
- R1: The input FIFO holds four entries, and `in_ready` is low exactly when all four are occupied. Entries reach memory in arrival order. A valid input with `in_eof` or `in_abort` set is a frame-end marker: it carries `in_status` and no data byte.
- R2: Each data byte is written at the address in the pointer register. The pointer advances by one for each write accepted with `mem_gnt` high.
- R3: After a write at the upper bound address, the next address used is the lower base address.
- R4: The pointer register (address 4) can be read at any time. Writing it moves the next write address.
- R5: Frame mode (mode 0) works as follows. Before the first entry of a frame, the two addresses at the pointer are reserved. The frame's data follow them. At the frame-end marker, the engine writes the data byte count into the first reserved byte. It writes {abort, in_status[6:0]} into the second. The pointer is left just after the last data byte.
- R6: In frame mode, cause bit 0 is set when the status byte of a frame has been written.
- R7: Periodic mode (mode 1) sets cause bit 1 once every n stored bytes, where n comes from the COUNT register. The counter loads n when the channel is enabled and reloads it after every interrupt. In modes 1 to 3, frame-end markers are dropped, with no memory write and no pointer change.
- R8: Silence mode (mode 2) sets cause bit 2 when TIMEOUT cycles pass after an arrival with no new character. Every arrival restarts the count. The timer is disarmed until the first character after enable.
- R9: Match mode (mode 3) sets cause bit 3 when a byte equal to an enabled match character is written to memory. The bit is not set while that byte waits in the FIFO. Disabled match characters never cause the bit to be set.
- R10: Cause bits in STATUS (address 1, bits 3:0) stay set until 1 is written to them. `irq` is the OR of the cause bits ANDed with the mask bits.
- R11: While the enable bit is low, nothing is written to memory and the FIFO keeps filling.
- R12: The register map uses 16-bit words. Address 0 is CTRL: bit 0 enable, bits 2:1 mode, bits 7:4 interrupt mask (one per cause, same order), bits 11:8 match enables. Address 2 is BASE, 3 is BOUND, 4 is the pointer, 5 is COUNT and 6 is TIMEOUT. Address 7 holds match characters 0 (low byte) and 1 (high byte), and address 8 holds 2 (low byte) and 3 (high byte). Address 9 reads the FIFO level. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive entry present |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Entry is a normal frame end |
| in_abort | input | 1 | Entry is an aborted frame end |
| in_status | input | 8 | Status that goes with a frame end |
| in_ready | output | 1 | FIFO can take an entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory accepts the write this cycle |
| irq | output | 1 | Maskable interrupt |

## Verification
The hardest case to reach is a matching byte that has arrived but has not been written yet. The bench holds `mem_gnt` low so the byte waits in the FIFO, confirms that the match bit stays clear and the FIFO level reads one, and then releases the grant. The other hard case is a full FIFO with the channel disabled. The bench fills the FIFO, drives a fifth entry that must be dropped, and only then enables periodic mode. This shows both the arrival order and the first reload of the counter on a burst that starts already queued.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [1:0] {
    MODE_FRAME  = 2'd0,
    MODE_PERIOD = 2'd1,
    MODE_SILENT = 2'd2,
    MODE_MATCH  = 2'd3
  } rx_mode_e;

  typedef struct packed {
    logic       eot;
    logic       abort;
    logic [7:0] data;
  } rx_entry_t;

  localparam logic [3:0] RA_CTRL   = 4'd0;
  localparam logic [3:0] RA_STATUS = 4'd1;
  localparam logic [3:0] RA_BASE   = 4'd2;
  localparam logic [3:0] RA_BOUND  = 4'd3;
  localparam logic [3:0] RA_PTR    = 4'd4;
  localparam logic [3:0] RA_COUNT  = 4'd5;
  localparam logic [3:0] RA_TMO    = 4'd6;
  localparam logic [3:0] RA_MLO    = 4'd7;
  localparam logic [3:0] RA_MHI    = 4'd8;
  localparam logic [3:0] RA_LEVEL  = 4'd9;

  localparam int CAUSE_FRAME  = 0;
  localparam int CAUSE_PERIOD = 1;
  localparam int CAUSE_SILENT = 2;
  localparam int CAUSE_MATCH  = 3;

endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10,
  localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   din,
  input  logic           pop,
  output logic [W-1:0]   dout,
  output logic           empty,
  output logic           full,
  output logic [LVW-1:0] level
);

  logic [W-1:0]   store_q [DEPTH];
  logic [LW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [LVW-1:0] lvl_q, lvl_d;

  function automatic logic [LW-1:0] bump(input logic [LW-1:0] p);
    return (p == LW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    lvl_d = lvl_q + LVW'(push) - LVW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= din;
  end

  assign dout  = store_q[rp_q];
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LVW'(DEPTH));
  assign level = lvl_q;

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVW'(DEPTH)); // R1

endmodule

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int TW  = 16,
  parameter int LVW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic [AW-1:0]      ptr,
  input  logic [3:0]         sticky,
  input  logic [LVW-1:0]     level,
  output logic               en,
  output logic               en_start,
  output rx_mode_e           mode,
  output logic [3:0]         mask,
  output logic [3:0]         match_en,
  output logic [3:0][7:0]    match_chars,
  output logic [AW-1:0]      base,
  output logic [AW-1:0]      bound,
  output logic [15:0]        period_n,
  output logic [TW-1:0]      tmo,
  output logic               ptr_wr,
  output logic [AW-1:0]      ptr_wdata,
  output logic [3:0]         clr
);

  logic [11:0]     ctrl_q;
  logic [AW-1:0]   base_q, bound_q;
  logic [15:0]     count_q;
  logic [TW-1:0]   tmo_q;
  logic [3:0][7:0] match_q;
  logic            en_d_q;

  logic wr_ctrl, wr_base, wr_bound, wr_count, wr_tmo, wr_mlo, wr_mhi;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
    wr_base  = reg_wr && (reg_addr == RA_BASE);
    wr_bound = reg_wr && (reg_addr == RA_BOUND);
    wr_count = reg_wr && (reg_addr == RA_COUNT);
    wr_tmo   = reg_wr && (reg_addr == RA_TMO);
    wr_mlo   = reg_wr && (reg_addr == RA_MLO);
    wr_mhi   = reg_wr && (reg_addr == RA_MHI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      bound_q <= '0;
      count_q <= '0;
      tmo_q   <= '0;
      match_q <= '0;
      en_d_q  <= 1'b0;
    end else begin
      en_d_q <= ctrl_q[0];
      if (wr_ctrl)  ctrl_q  <= reg_wdata[11:0];
      if (wr_base)  base_q  <= reg_wdata[AW-1:0];
      if (wr_bound) bound_q <= reg_wdata[AW-1:0];
      if (wr_count) count_q <= reg_wdata;
      if (wr_tmo)   tmo_q   <= reg_wdata[TW-1:0];
      if (wr_mlo) begin
        match_q[0] <= reg_wdata[7:0];
        match_q[1] <= reg_wdata[15:8];
      end
      if (wr_mhi) begin
        match_q[2] <= reg_wdata[7:0];
        match_q[3] <= reg_wdata[15:8];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:   reg_rdata[11:0]    = ctrl_q;
      RA_STATUS: reg_rdata[3:0]     = sticky;
      RA_BASE:   reg_rdata[AW-1:0]  = base_q;
      RA_BOUND:  reg_rdata[AW-1:0]  = bound_q;
      RA_PTR:    reg_rdata[AW-1:0]  = ptr;
      RA_COUNT:  reg_rdata          = count_q;
      RA_TMO:    reg_rdata[TW-1:0]  = tmo_q;
      RA_MLO:    reg_rdata          = {match_q[1], match_q[0]};
      RA_MHI:    reg_rdata          = {match_q[3], match_q[2]};
      RA_LEVEL:  reg_rdata[LVW-1:0] = level;
      default:   reg_rdata          = '0;
    endcase
  end

  assign en          = ctrl_q[0];
  assign en_start    = ctrl_q[0] && !en_d_q;
  assign mode        = rx_mode_e'(ctrl_q[2:1]);
  assign mask        = ctrl_q[7:4];
  assign match_en    = ctrl_q[11:8];
  assign match_chars = match_q;
  assign base        = base_q;
  assign bound       = bound_q;
  assign period_n    = count_q;
  assign tmo         = tmo_q;
  assign ptr_wr      = reg_wr && (reg_addr == RA_PTR);
  assign ptr_wdata   = reg_wdata[AW-1:0];
  assign clr         = (reg_wr && (reg_addr == RA_STATUS)) ? reg_wdata[3:0] : 4'b0;

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          en_start,
  input  rx_mode_e      mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] bound,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          fifo_empty,
  input  rx_entry_t     entry,
  output logic          fifo_pop,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  output logic [AW-1:0] ptr,
  output logic          byte_ev,
  output logic [7:0]    byte_val,
  output logic          frame_ev
);

  typedef enum logic [1:0] {ST_IDLE, ST_CNT, ST_STAT} eng_state_e;

  eng_state_e    st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d, hdr_q, hdr_d;
  logic          open_q, open_d, open_cur;
  logic [7:0]    cnt_q, cnt_d, cnt_cur;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    return (a == hi) ? lo : a + 1'b1;
  endfunction

  always_comb begin
    open_cur  = en_start ? 1'b0 : open_q;
    cnt_cur   = en_start ? 8'd0 : cnt_q;
    st_d      = st_q;
    ptr_d     = ptr_q;
    hdr_d     = hdr_q;
    open_d    = open_cur;
    cnt_d     = cnt_cur;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = entry.data;
    fifo_pop  = 1'b0;
    byte_ev   = 1'b0;
    frame_ev  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en && !fifo_empty) begin
          if (mode == MODE_FRAME && !open_cur) begin
            hdr_d  = ptr_q;
            ptr_d  = step(step(ptr_q, base, bound), base, bound);
            open_d = 1'b1;
          end else if (!entry.eot) begin
            mem_we = 1'b1;
            if (mem_gnt) begin
              fifo_pop = 1'b1;
              ptr_d    = step(ptr_q, base, bound);
              cnt_d    = cnt_cur + 8'd1;
              byte_ev  = 1'b1;
            end
          end else if (mode == MODE_FRAME) begin
            st_d = ST_CNT;
          end else begin
            fifo_pop = 1'b1;
          end
        end
      end
      ST_CNT: begin
        mem_we    = 1'b1;
        mem_addr  = hdr_q;
        mem_wdata = cnt_q;
        if (mem_gnt) st_d = ST_STAT;
      end
      ST_STAT: begin
        mem_we    = 1'b1;
        mem_addr  = step(hdr_q, base, bound);
        mem_wdata = {entry.abort, entry.data[6:0]};
        if (mem_gnt) begin
          fifo_pop = 1'b1;
          frame_ev = 1'b1;
          open_d   = 1'b0;
          cnt_d    = 8'd0;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (ptr_wr) ptr_d = ptr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      hdr_q  <= '0;
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      hdr_q  <= hdr_d;
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ptr      = ptr_q;
  assign byte_val = entry.data;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && !ptr_wr && ptr_q != bound) |=> ptr_q == $past(ptr_q) + 1'b1); // R2
  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && !ptr_wr && ptr_q == bound) |=> ptr_q == $past(base)); // R3
  AST_HDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CNT && mem_gnt) |=> (st_q == ST_STAT && mem_we)); // R5

endmodule

// File: rtl/rxdma_irq.sv
module rxdma_irq
  import rxdma_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            en_start,
  input  rx_mode_e        mode,
  input  logic            byte_ev,
  input  logic [7:0]      byte_val,
  input  logic            frame_ev,
  input  logic            arrive,
  input  logic [15:0]     period_n,
  input  logic [TW-1:0]   tmo,
  input  logic [3:0][7:0] match_chars,
  input  logic [3:0]      match_en,
  input  logic [3:0]      mask,
  input  logic [3:0]      clr,
  output logic [3:0]      sticky,
  output logic            irq
);

  logic [3:0]    sticky_q, sticky_d, ev;
  logic [15:0]   pcnt_q, pcnt_d, pcnt_cur;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          armed_q, armed_d;
  logic [3:0]    hit;

  for (genvar i = 0; i < 4; i++) begin : g_cmp
    assign hit[i] = match_en[i] && (byte_val == match_chars[i]);
  end

  always_comb begin
    ev       = '0;
    pcnt_cur = en_start ? period_n : pcnt_q;
    pcnt_d   = pcnt_cur;
    tcnt_d   = tcnt_q;
    armed_d  = armed_q;

    ev[CAUSE_FRAME] = frame_ev && (mode == MODE_FRAME);

    if (byte_ev && mode == MODE_PERIOD) begin
      if (pcnt_cur <= 16'd1) begin
        pcnt_d           = period_n;
        ev[CAUSE_PERIOD] = (period_n != 16'd0);
      end else begin
        pcnt_d = pcnt_cur - 16'd1;
      end
    end

    if (!en || en_start) begin
      armed_d = 1'b0;
      tcnt_d  = '0;
    end else if (arrive && mode == MODE_SILENT && tmo != '0) begin
      armed_d = 1'b1;
      tcnt_d  = '0;
    end else if (armed_q) begin
      if (tcnt_q == tmo - 1'b1) begin
        ev[CAUSE_SILENT] = 1'b1;
        armed_d          = 1'b0;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end

    ev[CAUSE_MATCH] = byte_ev && (mode == MODE_MATCH) && (|hit);

    sticky_d = (sticky_q & ~clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      pcnt_q   <= '0;
      tcnt_q   <= '0;
      armed_q  <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      pcnt_q   <= pcnt_d;
      tcnt_q   <= tcnt_d;
      armed_q  <= armed_d;
    end
  end

  assign sticky = sticky_q;
  assign irq    = |(sticky_q & mask);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky_q & ~clr)) |=> ((sticky_q & $past(sticky_q & ~clr)) == $past(sticky_q & ~clr))); // R10
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev[CAUSE_PERIOD] |=> pcnt_q == $past(period_n)); // R7
  AST_SILENT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ev[CAUSE_SILENT] |=> !armed_q); // R8

endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eof,
  input  logic          in_abort,
  input  logic [7:0]    in_status,
  output logic          in_ready,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  output logic          irq
);

  localparam int EW  = $bits(rx_entry_t);
  localparam int LVW = $clog2(DEPTH + 1);

  rx_entry_t       din, dout;
  logic            push, pop, empty, full, arrive;
  logic [LVW-1:0]  level;
  logic            en, en_start, ptr_wr;
  rx_mode_e        mode;
  logic [3:0]      mask, match_en, clr, sticky;
  logic [3:0][7:0] match_chars;
  logic [AW-1:0]   base, bound, ptr, ptr_wdata;
  logic [15:0]     period_n;
  logic [TW-1:0]   tmo;
  logic            byte_ev, frame_ev;
  logic [7:0]      byte_val;

  always_comb begin
    din.eot   = in_eof || in_abort;
    din.abort = in_abort;
    din.data  = din.eot ? in_status : in_data;
  end

  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign arrive   = push && !din.eot;

  rxdma_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(pop),
    .dout(dout), .empty(empty), .full(full), .level(level)
  );

  rxdma_regs #(.AW(AW), .TW(TW), .LVW(LVW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr(ptr), .sticky(sticky),
    .level(level), .en(en), .en_start(en_start), .mode(mode), .mask(mask),
    .match_en(match_en), .match_chars(match_chars), .base(base), .bound(bound),
    .period_n(period_n), .tmo(tmo), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .clr(clr)
  );

  rxdma_engine #(.AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .en_start(en_start), .mode(mode),
    .base(base), .bound(bound), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .fifo_empty(empty), .entry(dout), .fifo_pop(pop), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .ptr(ptr),
    .byte_ev(byte_ev), .byte_val(byte_val), .frame_ev(frame_ev)
  );

  rxdma_irq #(.TW(TW)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(en), .en_start(en_start), .mode(mode),
    .byte_ev(byte_ev), .byte_val(byte_val), .frame_ev(frame_ev),
    .arrive(arrive), .period_n(period_n), .tmo(tmo),
    .match_chars(match_chars), .match_en(match_en), .mask(mask), .clr(clr),
    .sticky(sticky), .irq(irq)
  );

  AST_NO_WRITE_IDLE_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_gnt && !frame_ev && empty) |-> 1'b0); // R11

endmodule

// File: tb/rxdma_chan_bench.sv
module rxdma_chan_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_eof, in_abort, in_ready;
  logic [7:0]  in_data, in_status;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        mem_we, mem_gnt, irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  rxdma_chan u_rxdma_chan (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_eof(in_eof), .in_abort(in_abort), .in_status(in_status),
    .in_ready(in_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we && mem_gnt) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic send(input logic [7:0] d, input logic eof, input logic ab, input logic [7:0] st);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_eof = eof; in_abort = ab; in_status = st;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R12", "irq after reset", irq, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R12", "mem_we after reset", mem_we, 0);
    rd(4'd0, v); chk("R12", "CTRL reset", v, 0);
    rd(4'd9, v); chk("R12", "LEVEL reset", v, 0);
  endtask

  task automatic t_periodic();
    logic [15:0] v;
    int w0;
    w0 = wr_cnt;
    send(8'h11, 0, 0, 0); send(8'h22, 0, 0, 0);
    send(8'h33, 0, 0, 0); send(8'h44, 0, 0, 0);
    idle(2);
    chk("R1", "in_ready when full", in_ready, 0);
    rd(4'd9, v); chk("R1", "level when full", v, 4);
    chk("R11", "no writes while disabled", wr_cnt - w0, 0);
    @(negedge clk); in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk); in_valid = 1'b0;
    wr(4'd2, 16'h0010); wr(4'd3, 16'h0017); wr(4'd4, 16'h0010);
    wr(4'd5, 16'd3);
    wr(4'd0, 16'h0023);
    idle(10);
    chk("R1", "order byte0", mem[8'h10], 8'h11);
    chk("R2", "order byte1", mem[8'h11], 8'h22);
    chk("R2", "order byte2", mem[8'h12], 8'h33);
    chk("R1", "order byte3, fifth dropped", mem[8'h13], 8'h44);
    rd(4'd4, v); chk("R4", "pointer after 4 bytes", v, 16'h14);
    rd(4'd1, v); chk("R7", "period cause after 3", v, 4'h2);
    chk("R10", "irq masked in", irq, 1);
    wr(4'd1, 16'h0002);
    rd(4'd1, v); chk("R10", "cause cleared", v, 0);
    chk("R10", "irq cleared", irq, 0);
    send(8'h55, 0, 0, 0);
    idle(4);
    rd(4'd1, v); chk("R7", "no cause mid period", v, 0);
    send(8'h66, 0, 0, 0);
    idle(4);
    rd(4'd1, v); chk("R7", "cause after reload", v, 4'h2);
    w0 = wr_cnt;
    send(8'h00, 1, 0, 8'h05);
    idle(4);
    chk("R7", "marker not written", wr_cnt - w0, 0);
    rd(4'd4, v); chk("R7", "marker leaves pointer", v, 16'h16);
    send(8'h77, 0, 0, 0); send(8'h88, 0, 0, 0); send(8'h99, 0, 0, 0);
    idle(4);
    chk("R3", "byte at bound", mem[8'h17], 8'h88);
    chk("R3", "byte wrapped to base", mem[8'h10], 8'h99);
    rd(4'd4, v); chk("R3", "pointer after wrap", v, 16'h11);
  endtask

  task automatic t_frame();
    logic [15:0] v;
    wr(4'd0, 16'h0000); wr(4'd1, 16'h000F);
    wr(4'd2, 16'h0020); wr(4'd3, 16'h003F); wr(4'd4, 16'h0020);
    wr(4'd0, 16'h0011);
    send(8'hA1, 0, 0, 0); send(8'hB2, 0, 0, 0); send(8'hC3, 0, 0, 0);
    send(8'h00, 1, 0, 8'h05);
    idle(8);
    chk("R5", "count byte", mem[8'h20], 3);
    chk("R5", "status byte", mem[8'h21], 8'h05);
    chk("R5", "first data after header", mem[8'h22], 8'hA1);
    chk("R5", "last data", mem[8'h24], 8'hC3);
    rd(4'd4, v); chk("R5", "pointer after frame", v, 16'h25);
    rd(4'd1, v); chk("R6", "frame cause", v, 4'h1);
    chk("R6", "frame irq", irq, 1);
    wr(4'd1, 16'h0001);
    send(8'hD4, 0, 0, 0); send(8'h00, 0, 1, 8'h01);
    idle(8);
    chk("R5", "second frame count", mem[8'h25], 1);
    chk("R5", "aborted status", mem[8'h26], 8'h81);
    chk("R5", "second frame data", mem[8'h27], 8'hD4);
    rd(4'd4, v); chk("R5", "pointer after second frame", v, 16'h28);
  endtask

  task automatic t_silent();
    logic [15:0] v;
    wr(4'd0, 16'h0000); wr(4'd1, 16'h000F);
    wr(4'd6, 16'd20);
    wr(4'd0, 16'h0045);
    idle(40);
    rd(4'd1, v); chk("R8", "disarmed before first char", v, 0);
    send(8'h31, 0, 0, 0);
    idle(10);
    send(8'h32, 0, 0, 0);
    idle(15);
    rd(4'd1, v); chk("R8", "restart on arrival", v, 0);
    idle(10);
    rd(4'd1, v); chk("R8", "silence cause", v, 4'h4);
    chk("R8", "silence irq", irq, 1);
  endtask

  task automatic t_match();
    logic [15:0] v;
    wr(4'd0, 16'h0000); wr(4'd1, 16'h000F);
    wr(4'd7, 16'h5541); wr(4'd8, 16'h007E);
    wr(4'd0, 16'h0587);
    @(negedge clk); mem_gnt = 1'b0;
    send(8'h7E, 0, 0, 0);
    idle(8);
    rd(4'd1, v); chk("R9", "no match while queued", v, 0);
    rd(4'd9, v); chk("R9", "byte waits in FIFO", v, 1);
    @(negedge clk); mem_gnt = 1'b1;
    idle(4);
    rd(4'd1, v); chk("R9", "match after write", v, 4'h8);
    chk("R9", "match irq", irq, 1);
    wr(4'd1, 16'h0008);
    send(8'h55, 0, 0, 0);
    idle(6);
    rd(4'd1, v); chk("R9", "disabled char ignored", v, 0);
    send(8'h41, 0, 0, 0);
    idle(6);
    rd(4'd1, v); chk("R9", "char 0 matches", v, 4'h8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_eof = 1'b0; in_abort = 1'b0;
    in_status = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; mem_gnt = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_frame();
    t_silent();
    t_match();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule